// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder/Decoder

This block sits between a UART-style serial port and an infrared transceiver. On the transmit side it takes the NRZ bit stream and emits a short, active-high optical pulse for every zero bit. One bits produce no pulse. On the receive side it watches the transceiver's active-low output. A glitch filter, measured in prescaler periods of the system clock, drops short pulses. Each surviving pulse becomes a zero bit on the NRZ receive line.

Two pulse-width modes are available. In the normal mode the transmit pulse is tied to the bit period and lasts three of the sixteen baud ticks in a bit. In the low-power mode the pulse lasts three prescaler periods, whatever the bit rate. The same prescaler sets the receive glitch thresholds in both modes. A prescaler of zero, or a low enable, shuts both directions down. The link is half duplex, so the receiver ignores the line while a zero bit is being sent. Framing, baud generation and turnaround timing belong to the surrounding UART and software.

Top module: `irda_sir_codec`

## Requirements
- R1: Out of reset, `ir_tx` is 0 and `rx_bit` is 1.
- R2: In normal mode (`low_power`=0), bits are sampled on every 16th `tick16` counted from enable. A sampled 0 drives `ir_tx` high for exactly 3 `tick16` periods from the sampling tick. A sampled 1 gives no pulse, so consecutive zero bits give rising edges 16 ticks apart.
- R3: In low-power mode (`low_power`=1), a sampled 0 drives `ir_tx` high for exactly 3×`prescale` clock cycles.
- R4: A low on `ir_rx` lasting fewer than 2×`prescale` clock cycles, including any pulse under one prescaler period, never drives `rx_bit` to 0.
- R5: A low on `ir_rx` lasting at least 2×`prescale` clock cycles drives `rx_bit` to 0.
- R6: After an accepted pulse, `rx_bit` stays 0 until 16 `tick16` pulses have passed since the synchronized falling edge of the latest `ir_rx` pulse, then returns to 1.
- R7: With `prescale`=0 or `enable`=0, `ir_tx` stays 0 and `rx_bit` stays 1 whatever the inputs.
- R8: While a zero bit is being sent or `ir_tx` is high, `rx_bit` is held at 1 and `ir_rx` pulses are discarded.
- R9: In low-power mode, the receive thresholds of R4 and R5 apply unchanged, in prescaler periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the encoder and decoder on |
| low_power | input | 1 | 1 selects prescaler-timed transmit pulses |
| prescale | input | 8 | Prescaler period in clock cycles; 0 disables |
| tick16 | input | 1 | One-cycle strobe at 16× the baud rate |
| tx_bit | input | 1 | NRZ transmit bit from the UART |
| ir_rx | input | 1 | Active-low pulse from the infrared receiver, idles high |
| ir_tx | output | 1 | Active-high pulse to the infrared emitter, idles low |
| rx_bit | output | 1 | Decoded NRZ receive bit, idles high |

## Verification
Transmit is tried with a long run of zero bits, then a run of one bits, in both pulse modes and at two prescaler values. Pulse width and rise-to-rise spacing together separate a tick-timed pulse from a prescaler-timed one, and a late or missing bit sample. Receive pulses are placed one clock below the threshold, exactly on it, and well under one prescaler period. This pins down the strict boundary in each mode. A looped-back echo and the disabled configurations show whether the receiver is gated rather than merely filtering.

// File: rtl/irda_cfg_pkg.sv
package irda_cfg_pkg;
    localparam int PSC_W       = 8;   // prescaler width
    localparam int BIT_TICKS   = 16;  // 16x ticks per bit
    localparam int PULSE_TICKS = 3;   // normal-mode pulse length in ticks
    localparam int LP_MULT     = 3;   // low-power pulse length in prescaler periods
    localparam int GLITCH_MULT = 2;   // accept threshold in prescaler periods
    localparam int SYNC_STAGES = 2;   // receive synchronizer depth
endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {STAGES{RST_VAL}};
        else        sync_q <= sync_d;
    end

    assign q = sync_q[STAGES-1];
endmodule

// File: rtl/irda_encoder.sv
module irda_encoder #(
    parameter int PSC_W       = irda_cfg_pkg::PSC_W,
    parameter int BIT_TICKS   = irda_cfg_pkg::BIT_TICKS,
    parameter int PULSE_TICKS = irda_cfg_pkg::PULSE_TICKS,
    parameter int LP_MULT     = irda_cfg_pkg::LP_MULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             low_power,
    input  logic [PSC_W-1:0] prescale,
    input  logic             tick16,
    input  logic             tx_bit,
    output logic             ir_tx,
    output logic             busy
);
    localparam int PH_W = $clog2(BIT_TICKS);
    localparam int LPW  = $clog2(LP_MULT * (2**PSC_W - 1) + 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            bitq;
        logic            irtx;
        logic [LPW-1:0]  lpcnt;
    } enc_t;

    enc_t st_d, st_q;
    logic off;
    logic [LPW-1:0] lp_len;

    assign off    = !enable || (prescale == '0);
    assign lp_len = LPW'(prescale) * LPW'(LP_MULT);

    always_comb begin
        st_d = st_q;
        if (off) begin
            st_d.phase = '0;
            st_d.bitq  = 1'b1;
            st_d.irtx  = 1'b0;
            st_d.lpcnt = '0;
        end else begin
            // low-power pulse length counted in clocks
            if (low_power && st_q.irtx) begin
                if (st_q.lpcnt <= LPW'(1)) st_d.irtx = 1'b0;
                if (st_q.lpcnt != '0)      st_d.lpcnt = st_q.lpcnt - LPW'(1);
            end
            // tick-driven bit sampling has priority over the pulse end
            if (tick16) begin
                st_d.phase = (st_q.phase == PH_W'(BIT_TICKS - 1)) ? '0 : st_q.phase + PH_W'(1);
                if (st_q.phase == '0) begin
                    st_d.bitq = tx_bit;
                    if (!tx_bit) begin
                        st_d.irtx  = 1'b1;
                        st_d.lpcnt = lp_len;
                    end
                end else if (!low_power && st_q.phase == PH_W'(PULSE_TICKS)) begin
                    st_d.irtx = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.bitq  <= 1'b1;
            st_q.irtx  <= 1'b0;
            st_q.lpcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_tx = st_q.irtx;
    assign busy  = st_q.irtx | ~st_q.bitq;

    assert_tx_idle_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !st_q.irtx);

    assert_normal_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_power && $rose(st_q.irtx)) |-> $past(tick16 && st_q.phase == '0 && !tx_bit));

    assert_lp_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !off && st_q.irtx) |-> (st_q.lpcnt != '0));
endmodule

// File: rtl/irda_decoder.sv
module irda_decoder #(
    parameter int PSC_W       = irda_cfg_pkg::PSC_W,
    parameter int BIT_TICKS   = irda_cfg_pkg::BIT_TICKS,
    parameter int GLITCH_MULT = irda_cfg_pkg::GLITCH_MULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] prescale,
    input  logic             tick16,
    input  logic             busy,
    input  logic             rx_s,
    output logic             rx_bit
);
    localparam int CW = $clog2(GLITCH_MULT * (2**PSC_W - 1) + 1);
    localparam int SW = $clog2(BIT_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] seen;
        logic          hold;
        logic          out;
        logic          prev;
    } dec_t;

    dec_t st_d, st_q;
    logic off, fall, accept;
    logic [CW-1:0] thr;

    assign off    = !enable || (prescale == '0);
    assign thr    = CW'(prescale) * CW'(GLITCH_MULT);
    assign fall   = st_q.prev & ~rx_s;
    assign accept = !rx_s && (st_q.cnt == thr - CW'(1));

    always_comb begin
        st_d      = st_q;
        st_d.prev = rx_s;
        if (off || busy) begin
            st_d.cnt  = '0;
            st_d.seen = SW'(BIT_TICKS);
            st_d.hold = 1'b0;
            st_d.out  = 1'b1;
        end else begin
            // low-time counter restarts whenever the line is high
            if (rx_s)                st_d.cnt = '0;
            else if (st_q.cnt < thr) st_d.cnt = st_q.cnt + CW'(1);
            // ticks since the latest falling edge
            if (fall)
                st_d.seen = '0;
            else if (tick16 && st_q.seen < SW'(BIT_TICKS))
                st_d.seen = st_q.seen + SW'(1);
            if (accept) begin
                st_d.out  = 1'b0;
                st_d.hold = 1'b1;
            end else if (st_q.hold && st_q.seen == SW'(BIT_TICKS)) begin
                st_d.out  = 1'b1;
                st_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.seen <= SW'(BIT_TICKS);
            st_q.hold <= 1'b0;
            st_q.out  <= 1'b1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_bit = st_q.out;

    assert_rx_idle_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> st_q.out);

    assert_echo_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> st_q.out);

    assert_accept_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.out) |-> $past(!rx_s && st_q.cnt == thr - CW'(1)));

    assert_low_has_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.out |-> st_q.hold);
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
    parameter int PSC_W       = irda_cfg_pkg::PSC_W,
    parameter int BIT_TICKS   = irda_cfg_pkg::BIT_TICKS,
    parameter int PULSE_TICKS = irda_cfg_pkg::PULSE_TICKS,
    parameter int LP_MULT     = irda_cfg_pkg::LP_MULT,
    parameter int GLITCH_MULT = irda_cfg_pkg::GLITCH_MULT,
    parameter int SYNC_STAGES = irda_cfg_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             low_power,
    input  logic [PSC_W-1:0] prescale,
    input  logic             tick16,
    input  logic             tx_bit,
    input  logic             ir_rx,
    output logic             ir_tx,
    output logic             rx_bit
);
    logic tx_busy;
    logic rx_sync;

    irda_encoder #(
        .PSC_W(PSC_W), .BIT_TICKS(BIT_TICKS),
        .PULSE_TICKS(PULSE_TICKS), .LP_MULT(LP_MULT)
    ) u_enc (
        .clk(clk), .rst_n(rst_n), .enable(enable), .low_power(low_power),
        .prescale(prescale), .tick16(tick16), .tx_bit(tx_bit),
        .ir_tx(ir_tx), .busy(tx_busy)
    );

    irda_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ir_rx), .q(rx_sync)
    );

    irda_decoder #(
        .PSC_W(PSC_W), .BIT_TICKS(BIT_TICKS), .GLITCH_MULT(GLITCH_MULT)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .tick16(tick16), .busy(tx_busy), .rx_s(rx_sync), .rx_bit(rx_bit)
    );
endmodule

// File: tb/test_irda_sir_codec.sv
`timescale 1ns/1ps
module test_irda_sir_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, low_power = 1'b0, tx_bit = 1'b1, rx_drv = 1'b1, loop = 1'b0;
    logic [7:0] prescale = 8'd4;
    logic [2:0] tdiv = '0;
    logic tick16, ir_rx, ir_tx, rx_bit;
    int n_run = 0, n_fail = 0;
    int run_len = 0, last_w = 0, n_pulse = 0, clk_cnt = 0, last_rise = 0, last_int = 0;
    int rx_low_cnt = 0;
    logic prev_tx = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    assign tick16 = (tdiv == 3'd7);
    assign ir_rx  = loop ? ~ir_tx : rx_drv;

    irda_sir_codec i_irda_sir_codec (
        .clk(clk), .rst_n(rst_n), .enable(enable), .low_power(low_power),
        .prescale(prescale), .tick16(tick16), .tx_bit(tx_bit), .ir_rx(ir_rx),
        .ir_tx(ir_tx), .rx_bit(rx_bit)
    );

    // tick generator and output monitors, all away from the active edge
    always @(negedge clk) begin
        tdiv    <= rst_n ? tdiv + 3'd1 : 3'd0;
        clk_cnt <= clk_cnt + 1;
        prev_tx <= ir_tx;
        if (ir_tx) run_len <= run_len + 1;
        else if (run_len > 0) begin
            last_w  <= run_len;
            n_pulse <= n_pulse + 1;
            run_len <= 0;
        end
        if (ir_tx && !prev_tx) begin
            last_int  <= clk_cnt - last_rise;
            last_rise <= clk_cnt;
        end
        if (!rx_bit) rx_low_cnt <= rx_low_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic config_mode(input logic lp, input logic [7:0] psc);
        @(negedge clk);
        enable = 1'b0;
        wait_clk(2);
        low_power = lp;
        prescale  = psc;
        enable    = 1'b1;
        wait_clk(2);
    endtask

    task automatic rx_pulse(input int len);
        @(negedge clk);
        rx_drv = 1'b0;
        wait_clk(len);
        rx_drv = 1'b1;
    endtask

    task automatic t_reset();
        wait_clk(3);
        chk(ir_tx == 1'b0, "R1 ir_tx in reset", int'(ir_tx), 0);
        chk(rx_bit == 1'b1, "R1 rx_bit in reset", int'(rx_bit), 1);
        rst_n = 1'b1;
        wait_clk(2);
        chk(ir_tx == 1'b0 && rx_bit == 1'b1, "R1 idle after reset", int'({ir_tx, rx_bit}), 1);
    endtask

    task automatic t_normal_tx();
        int n0, n1;
        config_mode(1'b0, 8'd4);
        tx_bit = 1'b0;
        n0 = n_pulse;
        wait_clk(5 * 128);
        chk(n_pulse - n0 >= 4, "R2 pulses for zero run", n_pulse - n0, 4);
        chk(last_w == 24, "R2 normal pulse width", last_w, 24);
        chk(last_int == 128, "R2 rise spacing", last_int, 128);
        tx_bit = 1'b1;
        wait_clk(160);
        n1 = n_pulse;
        wait_clk(3 * 128);
        chk(n_pulse == n1, "R2 one bits give no pulse", n_pulse - n1, 0);
    endtask

    task automatic t_lowpower_tx();
        config_mode(1'b1, 8'd5);
        tx_bit = 1'b0;
        wait_clk(4 * 128);
        chk(last_w == 15, "R3 low-power width psc=5", last_w, 15);
        chk(last_int == 128, "R3 low-power spacing", last_int, 128);
        config_mode(1'b1, 8'd1);
        wait_clk(3 * 128);
        chk(last_w == 3, "R3 low-power width psc=1", last_w, 3);
        tx_bit = 1'b1;
        wait_clk(256);
    endtask

    task automatic rx_case(input int len, input bit expect_low, input string tag);
        int c0;
        c0 = rx_low_cnt;
        rx_pulse(len);
        wait_clk(40);
        chk((rx_low_cnt != c0) == expect_low, tag, int'(rx_low_cnt != c0), int'(expect_low));
        wait_clk(200);
    endtask

    task automatic t_rx_normal();
        config_mode(1'b0, 8'd4);
        wait_clk(256);
        rx_case(3, 1'b0, "R4 pulse under one period");
        rx_case(7, 1'b0, "R4 pulse one below threshold");
        rx_case(8, 1'b1, "R5 pulse at threshold");
        rx_case(20, 1'b1, "R5 long pulse");
    endtask

    task automatic t_hold();
        rx_pulse(10);
        wait_clk(102);
        chk(rx_bit == 1'b0, "R6 still low before 16 ticks", int'(rx_bit), 0);
        wait_clk(38);
        chk(rx_bit == 1'b1, "R6 released after 16 ticks", int'(rx_bit), 1);
        wait_clk(100);
    endtask

    task automatic t_rx_lowpower();
        config_mode(1'b1, 8'd6);
        wait_clk(256);
        rx_case(5, 1'b0, "R9 low-power under one period");
        rx_case(11, 1'b0, "R9 low-power one below threshold");
        rx_case(12, 1'b1, "R9 low-power at threshold");
    endtask

    task automatic t_off(input logic en, input logic [7:0] psc, input string tag);
        int n0, c0;
        @(negedge clk);
        enable = 1'b0;
        low_power = 1'b0;
        prescale = psc;
        wait_clk(2);
        enable = en;
        tx_bit = 1'b0;
        n0 = n_pulse;
        c0 = rx_low_cnt;
        wait_clk(3 * 128);
        chk(n_pulse == n0 && run_len == 0, {tag, " no tx pulse"}, n_pulse - n0, 0);
        tx_bit = 1'b1;
        rx_pulse(40);
        wait_clk(40);
        chk(rx_low_cnt == c0, {tag, " rx stays idle"}, rx_low_cnt - c0, 0);
    endtask

    task automatic t_echo();
        int c0, n0;
        config_mode(1'b0, 8'd4);
        wait_clk(256);
        c0 = rx_low_cnt;
        n0 = n_pulse;
        loop = 1'b1;
        tx_bit = 1'b0;
        wait_clk(4 * 128);
        tx_bit = 1'b1;
        wait_clk(256);
        loop = 1'b0;
        chk(n_pulse - n0 >= 3, "R8 echo source pulses sent", n_pulse - n0, 3);
        chk(rx_low_cnt == c0, "R8 echo not decoded", rx_low_cnt - c0, 0);
    endtask

    initial begin
        t_reset();
        t_normal_tx();
        t_lowpower_tx();
        t_rx_normal();
        t_hold();
        t_rx_lowpower();
        t_off(1'b1, 8'd0, "R7 prescale zero");
        t_off(1'b0, 8'd4, "R7 enable low");
        t_echo();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
        $finish;
    end
endmodule